// File: doc/BRIEF.md
# Multi-Domain Reset Source Controller

This block collects every reset request in the device and drives three reset scopes. The system reset covers the core and peripherals. The power reset is a wider reset that also clears the cause flags. The backup-domain reset touches only the always-on backup logic. Requests come from several places: a software request from the core, a converted low-power entry (Stop or Standby), a write that forces an option reload, loss or return of the main supply, a Standby exit, and a software backup-reset bit. Two configuration inputs decide whether a low-power entry goes ahead or becomes a reset. When the entry becomes a reset, the block raises a suppress line in the same cycle, so the power controller stays out of the mode.

Each reset output comes from its own pulse stretcher. The stretcher holds the output for a fixed number of cycles after the last request cycle and releases it on a clock edge. Requests that overlap merge into one pulse. A small bank of sticky flags records which sources caused the system and power resets. Software can read the flags after it restarts. The flags survive system resets. They are cleared by a power reset or by an explicit clear strobe.

Top module: `rst_src_ctrl`

## Requirements
- R1: A high `sw_rst_req_i` at a clock edge starts a system reset and sets cause bit 0.
- R2: A `stop_entry_i` strobe while `stop_keep_cfg_i` is 0 drives `lp_block_o` high in the same cycle, starts a system reset and sets cause bit 1. With `stop_keep_cfg_i` at 1, the strobe causes no reset, no suppress and no flag.
- R3: A `stdby_entry_i` strobe while `stdby_keep_cfg_i` is 0 drives `lp_block_o` high in the same cycle, starts a system reset and sets cause bit 2. With `stdby_keep_cfg_i` at 1, the strobe has no effect.
- R4: A `flash_cr_wr_i` write whose data has bit 13 set starts a system reset and sets cause bit 3. A write with bit 13 clear, or bit 13 set without the write strobe, has no effect.
- R5: While the main supply is low, both `pwr_rst_o` and `sys_rst_o` are held and cause bit 4 is set. `main_pwr_ok_i` passes through one register stage before it is used.
- R6: A `stdby_exit_i` strobe starts a power reset, which also asserts the system reset, and sets cause bit 5.
- R7: A power request clears every cause flag that it does not set itself in the same cycle. System-only resets leave the flags unchanged.
- R8: `bkp_sw_rst_i` starts a backup-domain reset only. `sys_rst_o` and `pwr_rst_o` stay low.
- R9: The backup-domain reset is held while both supplies are low. It is released PULSE_W cycles after either supply returns. Loss of the main supply alone leaves `bkp_rst_o` low.
- R10: Every reset output is high out of `rst_ni`. Each output stays high for exactly PULSE_W cycles after the last request cycle, then falls on a clock edge.
- R11: `clr_flags_i` clears all cause flags. A cause set in the same cycle wins over the clear.
- R12: Requests that arrive in the same cycle give one pulse of PULSE_W cycles and set every cause bit involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_rst_req_i | input | 1 | Core software reset request |
| stop_entry_i | input | 1 | Stop entry sequence completed |
| stdby_entry_i | input | 1 | Standby entry sequence completed |
| stop_keep_cfg_i | input | 1 | 1: Stop entry proceeds, 0: it becomes a reset |
| stdby_keep_cfg_i | input | 1 | 1: Standby entry proceeds, 0: it becomes a reset |
| flash_cr_wr_i | input | 1 | Flash control register write strobe |
| flash_cr_wdata_i | input | FLASH_CR_W | Flash control register write data |
| bkp_sw_rst_i | input | 1 | Software backup-domain reset bit |
| main_pwr_ok_i | input | 1 | Main supply good |
| bat_pwr_ok_i | input | 1 | Battery supply good |
| stdby_exit_i | input | 1 | Standby exit event |
| clr_flags_i | input | 1 | Clear all cause flags |
| sys_rst_o | output | 1 | System reset, active high |
| pwr_rst_o | output | 1 | Power reset, active high |
| bkp_rst_o | output | 1 | Backup-domain reset, active high |
| lp_block_o | output | 1 | Suppress low-power entry |
| cause_o | output | 6 | Sticky cause flags, bits 0..5 as in R1 to R6 |

## Verification
The bench builds the block with its defaults: PULSE_W of 16, a 32-bit flash write bus, and the option-load field at bit 13. A pulse of 16 cycles is short enough to measure every release exactly, one cycle at a time. That makes off-by-one errors in the stretchers visible as a count of 15 or 17. Bit 12 sits next to the load field, so a write to it shows whether the decoder reads the wrong position. The supply tests hold the main supply and the battery low in turn. This separates the power scope from the backup scope.

// File: rtl/rst_src_pkg.sv
package rst_src_pkg;
  localparam int NUM_CAUSE = 6;
  localparam int C_SW       = 0;
  localparam int C_LP_STOP  = 1;
  localparam int C_LP_STDBY = 2;
  localparam int C_OPT_LOAD = 3;
  localparam int C_PWR_ON   = 4;
  localparam int C_STDBY_EX = 5;

  localparam int NUM_DOM = 3;
  localparam int D_SYS = 0;
  localparam int D_PWR = 1;
  localparam int D_BKP = 2;
endpackage

// File: rtl/rst_pulse_stretch.sv
module rst_pulse_stretch #(
  parameter int unsigned PULSE_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic rst_o
);
  localparam int unsigned CW = $clog2(PULSE_W + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_W);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LOAD;
      rst_q <= 1'b1;
    end else begin
      // output registered: high while the request or more than one count remains
      rst_q <= req_i || (cnt_q > ONE);
      if (req_i)            cnt_q <= LOAD;
      else if (cnt_q != '0) cnt_q <= cnt_q - ONE;
    end
  end

  assign rst_o = rst_q;
endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         pwr_clr_i,
  input  logic         sw_clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= ((pwr_clr_i || sw_clr_i) ? '0 : flags_q) | set_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
  import rst_src_pkg::*;
#(
  parameter int unsigned PULSE_W      = 16,
  parameter int unsigned FLASH_CR_W   = 32,
  parameter int unsigned OPT_LOAD_BIT = 13
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sw_rst_req_i,
  input  logic                  stop_entry_i,
  input  logic                  stdby_entry_i,
  input  logic                  stop_keep_cfg_i,
  input  logic                  stdby_keep_cfg_i,
  input  logic                  flash_cr_wr_i,
  input  logic [FLASH_CR_W-1:0] flash_cr_wdata_i,
  input  logic                  bkp_sw_rst_i,
  input  logic                  main_pwr_ok_i,
  input  logic                  bat_pwr_ok_i,
  input  logic                  stdby_exit_i,
  input  logic                  clr_flags_i,
  output logic                  sys_rst_o,
  output logic                  pwr_rst_o,
  output logic                  bkp_rst_o,
  output logic                  lp_block_o,
  output logic [NUM_CAUSE-1:0]  cause_o
);
  localparam logic [FLASH_CR_W-1:0] OBL_MASK = FLASH_CR_W'(1) << OPT_LOAD_BIT;

  logic main_ok_q, bat_ok_q;
  logic stop_conv, stdby_conv, obl_req, pwr_req, sys_req, bkp_req;
  logic [NUM_DOM-1:0]   dom_req, dom_rst;
  logic [NUM_CAUSE-1:0] cause_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_ok_q <= 1'b0;
      bat_ok_q  <= 1'b0;
    end else begin
      main_ok_q <= main_pwr_ok_i;
      bat_ok_q  <= bat_pwr_ok_i;
    end
  end

  assign stop_conv  = stop_entry_i  && !stop_keep_cfg_i;
  assign stdby_conv = stdby_entry_i && !stdby_keep_cfg_i;
  assign obl_req    = flash_cr_wr_i && |(flash_cr_wdata_i & OBL_MASK);
  assign pwr_req    = !main_ok_q || stdby_exit_i;
  assign sys_req    = sw_rst_req_i || stop_conv || stdby_conv || obl_req || pwr_req;
  // backup scope: own software bit, or both supplies absent
  assign bkp_req    = bkp_sw_rst_i || (!main_ok_q && !bat_ok_q);

  assign lp_block_o = stop_conv || stdby_conv;

  always_comb begin
    dom_req        = '0;
    dom_req[D_SYS] = sys_req;
    dom_req[D_PWR] = pwr_req;
    dom_req[D_BKP] = bkp_req;
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    rst_pulse_stretch #(.PULSE_W(PULSE_W)) i_stretch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (dom_req[d]),
      .rst_o (dom_rst[d])
    );
  end

  assign sys_rst_o = dom_rst[D_SYS];
  assign pwr_rst_o = dom_rst[D_PWR];
  assign bkp_rst_o = dom_rst[D_BKP];

  always_comb begin
    cause_set             = '0;
    cause_set[C_SW]       = sw_rst_req_i;
    cause_set[C_LP_STOP]  = stop_conv;
    cause_set[C_LP_STDBY] = stdby_conv;
    cause_set[C_OPT_LOAD] = obl_req;
    cause_set[C_PWR_ON]   = !main_ok_q;
    cause_set[C_STDBY_EX] = stdby_exit_i;
  end

  rst_cause_flags #(.N(NUM_CAUSE)) i_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (cause_set),
    .pwr_clr_i(pwr_req),
    .sw_clr_i (clr_flags_i),
    .flags_o  (cause_o)
  );
endmodule

// File: rtl/rst_src_ctrl_chk.sv
module rst_src_ctrl_chk #(
  parameter int unsigned PULSE_W      = 16,
  parameter int unsigned FLASH_CR_W   = 32,
  parameter int unsigned OPT_LOAD_BIT = 13
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sw_rst_req_i,
  input logic                  flash_cr_wr_i,
  input logic [FLASH_CR_W-1:0] flash_cr_wdata_i,
  input logic                  clr_flags_i,
  input logic                  pwr_req,
  input logic                  sys_rst_o,
  input logic                  pwr_rst_o,
  input logic                  lp_block_o,
  input logic [5:0]            cause_o
);
  localparam int unsigned HW = $clog2(PULSE_W + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hi_cnt <= '0;
    else if (!sys_rst_o)             hi_cnt <= '0;
    else if (hi_cnt != HW'(PULSE_W + 1)) hi_cnt <= hi_cnt + HW'(1);
  end

  a_r1_sw_starts_sys: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_req_i |=> sys_rst_o && cause_o[0]);

  a_r2_block_gives_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_block_o |=> sys_rst_o);

  a_r4_opt_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_cr_wr_i && flash_cr_wdata_i[OPT_LOAD_BIT]) |=> sys_rst_o && cause_o[3]);

  a_r6_pwr_covers_sys: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_rst_o |-> sys_rst_o);

  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o[0] && !clr_flags_i && !pwr_req) |=> cause_o[0]);

  a_r10_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_o && $past(sys_rst_o)) |-> (hi_cnt >= HW'(PULSE_W)));
endmodule

bind rst_src_ctrl rst_src_ctrl_chk #(
  .PULSE_W(PULSE_W), .FLASH_CR_W(FLASH_CR_W), .OPT_LOAD_BIT(OPT_LOAD_BIT)
) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .sw_rst_req_i    (sw_rst_req_i),
  .flash_cr_wr_i   (flash_cr_wr_i),
  .flash_cr_wdata_i(flash_cr_wdata_i),
  .clr_flags_i     (clr_flags_i),
  .pwr_req         (pwr_req),
  .sys_rst_o       (sys_rst_o),
  .pwr_rst_o       (pwr_rst_o),
  .lp_block_o      (lp_block_o),
  .cause_o         (cause_o)
);

// File: tb/test_rst_src_ctrl.sv
`timescale 1ns/1ps
module test_rst_src_ctrl;
  localparam int PW = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sw_rst_req_i = 0, stop_entry_i = 0, stdby_entry_i = 0;
  logic stop_keep_cfg_i = 1, stdby_keep_cfg_i = 1;
  logic flash_cr_wr_i = 0;
  logic [31:0] flash_cr_wdata_i = '0;
  logic bkp_sw_rst_i = 0, main_pwr_ok_i = 1, bat_pwr_ok_i = 1;
  logic stdby_exit_i = 0, clr_flags_i = 0;
  logic sys_rst_o, pwr_rst_o, bkp_rst_o, lp_block_o;
  logic [5:0] cause_o;

  int checks = 0, fails = 0;

  always #2.5 clk_i = ~clk_i;

  rst_src_ctrl i_rst_src_ctrl (.*);

  typedef struct packed {
    logic sw, stop, stdby, stop_keep, stdby_keep, wr, bit13, bit12, bkp;
    logic e_sys, e_bkp, e_blk;
    logic [5:0] e_flags;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1,0,0,1,1,0,0,0,0, 1,0,0, 6'b000001},  // R1
    '{0,1,0,0,1,0,0,0,0, 1,0,1, 6'b000010},  // R2 converted
    '{0,1,0,1,1,0,0,0,0, 0,0,0, 6'b000000},  // R2 kept
    '{0,0,1,1,0,0,0,0,0, 1,0,1, 6'b000100},  // R3 converted
    '{0,0,1,1,1,0,0,0,0, 0,0,0, 6'b000000},  // R3 kept
    '{0,0,0,1,1,1,1,0,0, 1,0,0, 6'b001000},  // R4 load bit
    '{0,0,0,1,1,1,0,1,0, 0,0,0, 6'b000000},  // R4 neighbour bit
    '{0,0,0,1,1,0,1,0,0, 0,0,0, 6'b000000},  // R4 no strobe
    '{0,0,0,1,1,0,0,0,1, 0,1,0, 6'b000000},  // R8
    '{1,1,0,0,1,0,0,0,0, 1,0,1, 6'b000011},  // R12 merge
    '{0,1,1,0,0,1,1,0,0, 1,0,1, 6'b001110}   // R12 merge
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic out_sel(input int s);
    return (s == 0) ? sys_rst_o : (s == 1) ? pwr_rst_o : bkp_rst_o;
  endfunction

  task automatic count_hi(input int s, output int n);
    n = 0;
    while (out_sel(s) && n < 200) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic wait_quiet();
    int g = 0;
    while ((sys_rst_o || pwr_rst_o || bkp_rst_o) && g < 500) begin
      g++;
      @(negedge clk_i);
    end
  endtask

  task automatic clear_flags();
    clr_flags_i = 1;
    @(negedge clk_i);
    clr_flags_i = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    int n;
    vec_t v;
    // reset state
    repeat (3) @(negedge clk_i);
    chk("R10 sys out of reset", sys_rst_o, 1);
    chk("R10 pwr out of reset", pwr_rst_o, 1);
    chk("R10 bkp out of reset", bkp_rst_o, 1);
    chk("R2 block in reset", lp_block_o, 0);
    chk("R7 flags in reset", cause_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    wait_quiet();
    chk("R5 power-on flag", cause_o, 6'b010000);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      wait_quiet();
      clear_flags();
      chk("R11 clear", cause_o, 0);
      sw_rst_req_i = v.sw; stop_entry_i = v.stop; stdby_entry_i = v.stdby;
      stop_keep_cfg_i = v.stop_keep; stdby_keep_cfg_i = v.stdby_keep;
      flash_cr_wr_i = v.wr;
      flash_cr_wdata_i = {18'd0, v.bit13, v.bit12, 12'd0};
      bkp_sw_rst_i = v.bkp;
      #1;
      chk($sformatf("R2 R3 block vec%0d", i), lp_block_o, v.e_blk);
      @(negedge clk_i);
      sw_rst_req_i = 0; stop_entry_i = 0; stdby_entry_i = 0;
      stop_keep_cfg_i = 1; stdby_keep_cfg_i = 1;
      flash_cr_wr_i = 0; flash_cr_wdata_i = '0; bkp_sw_rst_i = 0;
      chk($sformatf("R1 R4 sys vec%0d", i), sys_rst_o, v.e_sys);
      chk($sformatf("R8 pwr vec%0d", i), pwr_rst_o, 0);
      chk($sformatf("R8 bkp vec%0d", i), bkp_rst_o, v.e_bkp);
      chk($sformatf("R12 flags vec%0d", i), cause_o, v.e_flags);
      if (v.e_sys) begin
        count_hi(0, n);
        chk($sformatf("R10 sys width vec%0d", i), n, PW);
      end else if (v.e_bkp) begin
        count_hi(2, n);
        chk($sformatf("R10 bkp width vec%0d", i), n, PW);
      end else begin
        repeat (20) begin
          @(negedge clk_i);
          if (sys_rst_o || bkp_rst_o) n = -1;
        end
        chk($sformatf("R4 no reset vec%0d", i), n == -1, 0);
      end
      chk($sformatf("R7 flags kept vec%0d", i), cause_o, v.e_flags);
    end

    // R11: set wins over clear
    wait_quiet();
    clear_flags();
    sw_rst_req_i = 1; clr_flags_i = 1;
    @(negedge clk_i);
    sw_rst_req_i = 0; clr_flags_i = 0;
    chk("R11 set wins", cause_o, 6'b000001);
    wait_quiet();
    chk("R7 survives sys reset", cause_o, 6'b000001);

    // R6 + R7: standby exit
    stdby_exit_i = 1;
    @(negedge clk_i);
    stdby_exit_i = 0;
    chk("R6 pwr", pwr_rst_o, 1);
    chk("R6 sys", sys_rst_o, 1);
    chk("R7 pwr clears others", cause_o, 6'b100000);
    count_hi(1, n);
    chk("R10 pwr width", n, PW);

    // R5 + R9: main supply lost, battery on
    wait_quiet();
    clear_flags();
    main_pwr_ok_i = 0;
    repeat (5) @(negedge clk_i);
    chk("R5 pwr held", pwr_rst_o, 1);
    chk("R5 sys held", sys_rst_o, 1);
    chk("R9 bkp untouched", bkp_rst_o, 0);
    chk("R5 flag", cause_o, 6'b010000);
    main_pwr_ok_i = 1;
    @(negedge clk_i);
    count_hi(1, n);
    chk("R5 pwr release", n, PW);

    // R9: both supplies lost
    wait_quiet();
    main_pwr_ok_i = 0; bat_pwr_ok_i = 0;
    repeat (5) @(negedge clk_i);
    chk("R9 bkp held", bkp_rst_o, 1);
    bat_pwr_ok_i = 1;
    @(negedge clk_i);
    count_hi(2, n);
    chk("R9 bkp release", n, PW);
    chk("R9 pwr still held", pwr_rst_o, 1);
    main_pwr_ok_i = 1;
    @(negedge clk_i);
    count_hi(1, n);
    chk("R5 pwr release after both", n, PW);
    chk("R9 bkp stays low", bkp_rst_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule